// File: doc/BRIEF.md
# Flash-Mode Entry and Mode Supervisor

This block is the mode-control state machine of a supervisory companion chip. It accepts 3-bit operating-mode codes, each delivered with a one-cycle write strobe. It tracks four modes: Start-up, Normal, Flash (firmware update) and Fail-safe. Whenever the microcontroller must be restarted, it drives a system reset pulse and records why.

Flash mode is reached only through a two-step handshake. The first step must arrive within an initial window after Start-up begins, and the handshake can complete once per power-on. While in Flash mode, the watchdog is fed with one dedicated code. A watchdog overflow, a correct exit or any other code leaves Flash mode through a reset, and each of these records its own reason. A missing oscillator overrides everything: the block parks in Fail-safe with the reset held. It comes back only when the clock is good again and a wake-up is seen.

The serial interface, the watchdog timer and the oscillator detector are outside this block. The watchdog timer takes a one-cycle feed pulse from here and returns an overflow flag.

Top module: `fmode_sup`

## Requirements
- R1: After power-on reset: `mode_o` = Start-up (2'd0), `sys_rst` = 0, `rst_src` = none (3'd0), `wd_kick` = 0. Mode encodings are Start-up 0, Normal 1, Flash 2, Fail-safe 3.
- R2: In Start-up, code 3'b011 written while the initial window is open arms Flash entry, provided Flash has not yet been used since power-on. It starts a reset pulse of `RST_LEN` cycles, sets `rst_src` to 3'd4 (entry handshake), keeps the mode at Start-up and restarts the window.
- R3: Once armed, a second 3'b011 in Start-up within the window enters Flash without a reset and clears `rst_src` to 0. After Flash has been entered once, 3'b011 is ignored until the next power-on reset.
- R4: Code 3'b101 in Start-up enters Normal and discards any armed entry, so a later 3'b011 re-arms instead of entering Flash.
- R5: In Flash, code 3'b111 produces a one-cycle `wd_kick` pulse on the cycle after the write, with no reset and no mode change.
- R6: In Flash, `wd_ovf` forces a reset pulse, `rst_src` = 3'd1 and a return to Start-up, taking precedence over a write in the same cycle.
- R7: In Flash, code 3'b110 causes a reset pulse, `rst_src` = 3'd3 (Flash exit) and a return to Start-up.
- R8: In Flash, every code other than 3'b111 and 3'b110 causes a reset pulse, `rst_src` = 3'd2 (illegal code) and a return to Start-up.
- R9: When `osc_ok` is low at a clock edge, the next cycle shows Fail-safe with `rst_src` = 3'd5. `sys_rst` stays high for as long as Fail-safe lasts, and mode writes have no effect there.
- R10: Fail-safe is left only on a cycle with both `osc_ok` and `wake` high. The block then goes to Start-up with a fresh reset pulse of `RST_LEN` cycles.
- R11: Writes arriving while the reset pulse is active are ignored. `rst_src` keeps its value until a write is accepted, and an accepted write that records no reason clears it to 0.
- R12: Once `INIT_WIN` cycles have passed since Start-up was entered or the window was last restarted, 3'b011 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_stb | input | 1 | Mode-code write strobe, one cycle per write |
| wr_code | input | 3 | Operating-mode code |
| wd_ovf | input | 1 | Overflow flag from the external watchdog timer |
| osc_ok | input | 1 | High while the oscillator runs at normal frequency |
| wake | input | 1 | Wake-up event |
| mode_o | output | 2 | Current mode (0 Start-up, 1 Normal, 2 Flash, 3 Fail-safe) |
| sys_rst | output | 1 | System reset to the microcontroller |
| rst_src | output | 3 | Reason for the latest reset |
| wd_kick | output | 1 | One-cycle watchdog feed pulse |

## Verification
The bench builds the block with `RST_LEN` = 16, the default pulse length, and `INIT_WIN` = 40. With these values the window closes about 24 cycles after a handshake pulse ends. Both an in-window completion and a late, ignored 3'b011 therefore fall within a short run. A small window also makes it cheap to repeat a full power-on, handshake and Flash entry for every one of the eight codes. The complete code sweep in Flash mode is made possible by this, together with the fixed pulse length, which each reset is measured against.

// File: rtl/fms_pkg.sv
package fms_pkg;

    typedef enum logic [1:0] {
        MD_STARTUP  = 2'd0,
        MD_NORMAL   = 2'd1,
        MD_FLASH    = 2'd2,
        MD_FAILSAFE = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SRC_NONE    = 3'd0,
        SRC_WDOG    = 3'd1,
        SRC_ILLEGAL = 3'd2,
        SRC_FEXIT   = 3'd3,
        SRC_FENTRY  = 3'd4,
        SRC_OSC     = 3'd5
    } src_e;

    typedef enum logic [2:0] {
        K_ENTRY,
        K_NORMAL,
        K_SERVE,
        K_EXIT,
        K_OTHER
    } kind_e;

    localparam logic [2:0] CODE_ENTRY  = 3'b011;
    localparam logic [2:0] CODE_NORMAL = 3'b101;
    localparam logic [2:0] CODE_SERVE  = 3'b111;
    localparam logic [2:0] CODE_EXIT   = 3'b110;

    typedef struct packed {
        mode_e mode;
        src_e  src;
        logic  armed;
        logic  used;
    } sup_state_t;

    function automatic kind_e classify(input logic [2:0] code);
        case (code)
            CODE_ENTRY:  return K_ENTRY;
            CODE_NORMAL: return K_NORMAL;
            CODE_SERVE:  return K_SERVE;
            CODE_EXIT:   return K_EXIT;
            default:     return K_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/fms_decode.sv
module fms_decode
    import fms_pkg::*;
(
    input  logic [2:0] code,
    output kind_e      kind
);
    always_comb kind = classify(code);
endmodule

// File: rtl/fms_pulse.sv
module fms_pulse #(
    parameter int RST_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cancel,
    output logic busy
);
    localparam int CW = $clog2(RST_LEN + 1);
    localparam logic [CW-1:0] LEN = CW'(RST_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LEN;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/fms_window.sv
module fms_window #(
    parameter int INIT_WIN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic open
);
    localparam int CW = $clog2(INIT_WIN + 1);
    localparam logic [CW-1:0] LIM = CW'(INIT_WIN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && cnt < LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign open = (cnt < LIM);
endmodule

// File: rtl/fmode_sup.sv
module fmode_sup
    import fms_pkg::*;
#(
    parameter int RST_LEN  = 16,
    parameter int INIT_WIN = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  logic [2:0] wr_code,
    input  logic       wd_ovf,
    input  logic       osc_ok,
    input  logic       wake,
    output logic [1:0] mode_o,
    output logic       sys_rst,
    output logic [2:0] rst_src,
    output logic       wd_kick
);
    sup_state_t cur, nxt;
    kind_e      kind;
    logic       busy, win_open;
    logic       load, cancel, restart, kick_n, accept;

    fms_decode u_dec (
        .code (wr_code),
        .kind (kind)
    );

    fms_pulse #(.RST_LEN(RST_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cancel (cancel),
        .busy   (busy)
    );

    fms_window #(.INIT_WIN(INIT_WIN)) u_win (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (cur.mode == MD_STARTUP),
        .open    (win_open)
    );

    // Helper: a reset that sends the block back to Start-up with a reason.
    function automatic sup_state_t to_startup(input sup_state_t s, input src_e why);
        sup_state_t r;
        r      = s;
        r.mode = MD_STARTUP;
        r.src  = why;
        return r;
    endfunction

    always_comb begin
        nxt     = cur;
        load    = 1'b0;
        cancel  = 1'b0;
        restart = 1'b0;
        kick_n  = 1'b0;
        accept  = wr_stb && !busy;

        if (!osc_ok) begin
            cancel = 1'b1;
            if (cur.mode != MD_FAILSAFE) begin
                nxt.mode = MD_FAILSAFE;
                nxt.src  = SRC_OSC;
            end
        end else begin
            case (cur.mode)
                MD_FAILSAFE: begin
                    if (wake) begin
                        nxt.mode = MD_STARTUP;
                        load     = 1'b1;
                        restart  = 1'b1;
                    end
                end
                MD_STARTUP: begin
                    if (accept) begin
                        case (kind)
                            K_ENTRY: begin
                                if (win_open && !cur.used) begin
                                    if (cur.armed) begin
                                        nxt.mode  = MD_FLASH;
                                        nxt.armed = 1'b0;
                                        nxt.used  = 1'b1;
                                        nxt.src   = SRC_NONE;
                                    end else begin
                                        nxt.armed = 1'b1;
                                        nxt.src   = SRC_FENTRY;
                                        load      = 1'b1;
                                        restart   = 1'b1;
                                    end
                                end
                            end
                            K_NORMAL: begin
                                nxt.mode  = MD_NORMAL;
                                nxt.armed = 1'b0;
                                nxt.src   = SRC_NONE;
                            end
                            default: ;
                        endcase
                    end
                end
                MD_FLASH: begin
                    if (wd_ovf) begin
                        nxt     = to_startup(cur, SRC_WDOG);
                        load    = 1'b1;
                        restart = 1'b1;
                    end else if (accept) begin
                        case (kind)
                            K_SERVE: begin
                                kick_n = 1'b1;
                            end
                            K_EXIT: begin
                                nxt     = to_startup(cur, SRC_FEXIT);
                                load    = 1'b1;
                                restart = 1'b1;
                            end
                            default: begin
                                nxt     = to_startup(cur, SRC_ILLEGAL);
                                load    = 1'b1;
                                restart = 1'b1;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.mode  <= MD_STARTUP;
            cur.src   <= SRC_NONE;
            cur.armed <= 1'b0;
            cur.used  <= 1'b0;
            wd_kick   <= 1'b0;
        end else begin
            cur     <= nxt;
            wd_kick <= kick_n;
        end
    end

    assign mode_o  = cur.mode;
    assign rst_src = cur.src;
    assign sys_rst = busy || (cur.mode == MD_FAILSAFE);
endmodule

// File: rtl/fms_checker.sv
module fms_checker
    import fms_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic [2:0] wr_code,
    input logic       wd_ovf,
    input logic       osc_ok,
    input logic       wake,
    input logic [1:0] mode_o,
    input logic       sys_rst,
    input logic [2:0] rst_src,
    input logic       wd_kick
);
    p_flash_no_rst_r3: assert property (@(posedge clk) disable iff (rst)
        mode_o == MD_FLASH |-> !sys_rst);

    p_kick_in_flash_r5: assert property (@(posedge clk) disable iff (rst)
        wd_kick |-> (mode_o == MD_FLASH && !sys_rst));

    p_wdog_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_FLASH && osc_ok && wd_ovf)
        |=> (mode_o == MD_STARTUP && sys_rst && rst_src == SRC_WDOG));

    p_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_FLASH && osc_ok && !wd_ovf && wr_stb && wr_code == CODE_EXIT)
        |=> (mode_o == MD_STARTUP && sys_rst && rst_src == SRC_FEXIT));

    p_failsafe_rst_r9: assert property (@(posedge clk) disable iff (rst)
        mode_o == MD_FAILSAFE |-> sys_rst);

    p_osc_fail_r9: assert property (@(posedge clk) disable iff (rst)
        !osc_ok |=> (mode_o == MD_FAILSAFE && rst_src == SRC_OSC));

    p_stay_failsafe_r10: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_FAILSAFE && !(osc_ok && wake)) |=> mode_o == MD_FAILSAFE);

    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && mode_o != MD_FAILSAFE && osc_ok && wr_stb)
        |=> ($stable(mode_o) && $stable(rst_src)));
endmodule

bind fmode_sup fms_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_code (wr_code),
    .wd_ovf  (wd_ovf),
    .osc_ok  (osc_ok),
    .wake    (wake),
    .mode_o  (mode_o),
    .sys_rst (sys_rst),
    .rst_src (rst_src),
    .wd_kick (wd_kick)
);

// File: tb/fmode_sup_bench.sv
`timescale 1ns/1ps
module fmode_sup_bench;
    localparam int RL = 16;
    localparam int IW = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [2:0] wr_code = 3'b000;
    logic       wd_ovf = 1'b0;
    logic       osc_ok = 1'b1;
    logic       wake = 1'b0;
    logic [1:0] mode_o;
    logic       sys_rst;
    logic [2:0] rst_src;
    logic       wd_kick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fmode_sup #(.RST_LEN(RL), .INIT_WIN(IW)) u_fmode_sup (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_code(wr_code),
        .wd_ovf(wd_ovf), .osc_ok(osc_ok), .wake(wake),
        .mode_o(mode_o), .sys_rst(sys_rst), .rst_src(rst_src), .wd_kick(wd_kick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic state_is(input string req, input int m, input int r, input int s);
        chk(mode_o == m, {req, " mode"}, mode_o, m);
        chk(sys_rst == r, {req, " sys_rst"}, sys_rst, r);
        chk(rst_src == s, {req, " rst_src"}, rst_src, s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] c);
        wr_stb  = 1'b1;
        wr_code = c;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic pulse_len(input string req);
        int n = 0;
        while (sys_rst && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == RL, {req, " pulse length"}, n, RL);
    endtask

    task automatic power_on();
        rst = 1'b1; wr_stb = 1'b0; wd_ovf = 1'b0; osc_ok = 1'b1; wake = 1'b0;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic go_flash(input string req);
        wr(3'b011);
        state_is({req, " arm"}, 0, 1, 4);
        pulse_len(req);
        wr(3'b011);
        state_is({req, " enter"}, 2, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        power_on();
        state_is("R1 reset", 0, 0, 0);
        chk(wd_kick == 1'b0, "R1 kick", wd_kick, 0);

        // R2 arm, R11 ignored during pulse, R4 normal
        wr(3'b011);
        state_is("R2 arm", 0, 1, 4);
        wr(3'b101);
        state_is("R11 write during pulse", 0, 1, 4);
        while (sys_rst) @(negedge clk);
        wr(3'b101);
        state_is("R4 normal", 1, 0, 0);
        wr(3'b011);
        state_is("R4 normal ignores", 1, 0, 0);

        // R9 fail-safe, R10 recovery
        osc_ok = 1'b0;
        @(negedge clk);
        state_is("R9 osc fail", 3, 1, 5);
        wr(3'b101);
        state_is("R9 write ignored", 3, 1, 5);
        wake = 1'b1;
        idle(2);
        state_is("R10 wake without osc", 3, 1, 5);
        wake = 1'b0;
        osc_ok = 1'b1;
        idle(3);
        state_is("R10 osc without wake", 3, 1, 5);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        state_is("R10 recover", 0, 1, 5);
        pulse_len("R10");
        chk(rst_src == 5, "R11 src held", rst_src, 5);

        // R4: arming was discarded, so 011 re-arms rather than entering Flash
        go_flash("R4 rearm");

        // R5 service
        for (int k = 0; k < 3; k++) begin
            wr(3'b111);
            chk(wd_kick == 1'b1, "R5 kick high", wd_kick, 1);
            state_is("R5 serve", 2, 0, 0);
            @(negedge clk);
            chk(wd_kick == 1'b0, "R5 kick one cycle", wd_kick, 0);
        end

        // R7 exit
        wr(3'b110);
        state_is("R7 exit", 0, 1, 3);
        pulse_len("R7");
        // R3 only once per power-on
        wr(3'b011);
        state_is("R3 once", 0, 0, 3);
        wr(3'b011);
        state_is("R3 once again", 0, 0, 3);

        // R6 overflow, also beats a simultaneous exit write
        power_on();
        go_flash("R6");
        wd_ovf = 1'b1;
        wr(3'b110);
        wd_ovf = 1'b0;
        state_is("R6 overflow", 0, 1, 1);
        pulse_len("R6");

        // R12 window expiry
        power_on();
        idle(IW + 5);
        wr(3'b011);
        state_is("R12 late entry", 0, 0, 0);
        power_on();
        wr(3'b011);
        state_is("R12 arm", 0, 1, 4);
        idle(IW + 5);
        wr(3'b011);
        state_is("R12 late completion", 0, 0, 4);

        // R8 sweep over all codes in Flash
        for (int c = 0; c < 8; c++) begin
            power_on();
            go_flash("R8 setup");
            wr(3'(c));
            if (c == 7) begin
                state_is("R8 serve code", 2, 0, 0);
            end else if (c == 6) begin
                state_is("R8 exit code", 0, 1, 3);
            end else begin
                state_is("R8 illegal code", 0, 1, 2);
                pulse_len("R8");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule